// File: doc/BRIEF.md
# BCD Alarm Comparator with Repeat Masking

This block keeps an alarm setting as four byte-wide registers (second, minute, hour and day of month, all in BCD) and compares them against a running BCD time of day. The time of day comes from a separate timekeeping counter. On each one-second tick from that counter, the block decides whether the alarm fires. When it fires and the alarm is enabled, it emits a one-cycle interrupt pulse.

Bit 7 of each alarm register is a repeat mask. Together, the four mask bits choose how much of the time of day must match, and so they set how often the alarm fires: monthly, daily, hourly, every minute or every second. Software loads the registers over a plain byte write port and can read them back through a combinational read port. A write that does not hold a valid BCD value for its field is dropped without effect.

Top module: `bcd_alarm_top`

## Requirements
- R1: After reset, all four alarm registers and the enable bit read 0x00, and `irq` is low.
- R2: Register map: address 0 is the alarm second, 1 the alarm minute, 2 the alarm hour, 3 the alarm date, and 4 is control (bit 0 is the interrupt enable, other bits read 0). `rd_data` shows the addressed register in the same cycle. Any other address reads 0x00, and writes to it change nothing.
- R3: A write to the second or minute register is accepted only if bits 6:0 form BCD 00 to 59, with both nibbles 9 or less. Otherwise the register keeps its old value.
- R4: A write to the hour register is accepted only if bits 5:0 form BCD 00 to 23, with the low nibble 9 or less. Otherwise the register keeps its old value.
- R5: A write to the date register is accepted only if bits 5:0 form a BCD value other than zero, with the low nibble 9 or less. Otherwise the register keeps its old value.
- R6: An accepted write stores all 8 bits, including the mask bit 7 and any unchecked upper bits.
- R7: When all four mask bits are clear, the alarm matches only if every field is equal. The fields compared are second bits 6:0, minute bits 6:0, hour bits 5:0 and date bits 5:0.
- R8: These mask patterns compare fewer fields. With only the date mask set, hour, minute and second are compared (daily). With the date and hour masks set, minute and second are compared (hourly). With the date, hour and minute masks set, only second is compared (every minute).
- R9: Every other mask combination matches on every tick (every second).
- R10: A match counts only in a cycle where `tick` is high. `irq` rises on the clock edge that samples that tick and stays high for exactly one cycle.
- R11: While the enable bit is 0, `irq` stays low whatever the match result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 1 | One-second tick from the timekeeper |
| tod_sec | input | 8 | Current second, BCD |
| tod_min | input | 8 | Current minute, BCD |
| tod_hour | input | 8 | Current hour, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A write is committed on the clock edge that samples `wr_en`. Because `rd_data` is combinational, the new value is visible through the read port half a cycle later. The bench therefore drives every stimulus on the falling edge and checks readback on the following falling edge. The interrupt has one register between `tick` and `irq`. So `irq` is checked at the falling edge just after the tick is sampled, and it is checked low again one cycle later to confirm the pulse is a single cycle wide. Every write value is swept for every alarm field, and all sixteen mask patterns are tried against time patterns that differ in exactly one field.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int FIELDS   = 4;
  localparam int F_SEC    = 0;
  localparam int F_MIN    = 1;
  localparam int F_HOUR   = 2;
  localparam int F_DATE   = 3;
  localparam int MASK_BIT = 7;

  typedef enum logic [2:0] {
    RPT_MONTH, RPT_DAY, RPT_HOUR, RPT_MINUTE, RPT_SECOND
  } repeat_e;

  // Write acceptance check for one alarm field.
  function automatic logic field_ok(input int idx, input logic [7:0] v);
    logic [3:0] lo;
    logic [2:0] hi;
    lo = v[3:0];
    hi = v[6:4];
    case (idx)
      F_SEC, F_MIN: field_ok = (lo <= 4'd9) && (hi <= 3'd5);
      F_HOUR:       field_ok = (lo <= 4'd9) &&
                               ((v[5:4] < 2'd2) || (v[5:4] == 2'd2 && lo <= 4'd3));
      F_DATE:       field_ok = (lo <= 4'd9) && (v[5:0] != 6'd0);
      default:      field_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic [FIELDS-1:0][7:0]  alarm_q,
  output logic                    en_q
);
  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    logic [7:0] q;
    logic       accept;
    assign accept = wr_en && (wr_addr == ADDR_W'(g)) && field_ok(g, wr_data);
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= 8'h00;
      else if (accept) q <= wr_data;
    end
    assign alarm_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                          en_q <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))     en_q <= wr_data[0];
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = {7'd0, en_q};
    else if (int'(rd_addr) < FIELDS)   rd_data = alarm_q[rd_addr[1:0]];
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic [FIELDS-1:0][7:0] alarm_q,
  input  logic [7:0]             tod_sec,
  input  logic [7:0]             tod_min,
  input  logic [7:0]             tod_hour,
  input  logic [7:0]             tod_date,
  output logic                   hit
);
  logic [FIELDS-1:0] masks;
  repeat_e           mode;
  logic eq_sec, eq_min, eq_hour, eq_date;

  for (genvar g = 0; g < FIELDS; g++) begin : g_mask
    assign masks[g] = alarm_q[g][MASK_BIT];
  end

  always_comb begin
    case (masks)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  assign eq_sec  = alarm_q[F_SEC][6:0]  == tod_sec[6:0];
  assign eq_min  = alarm_q[F_MIN][6:0]  == tod_min[6:0];
  assign eq_hour = alarm_q[F_HOUR][5:0] == tod_hour[5:0];
  assign eq_date = alarm_q[F_DATE][5:0] == tod_date[5:0];

  always_comb begin
    case (mode)
      RPT_MONTH:  hit = eq_date && eq_hour && eq_min && eq_sec;
      RPT_DAY:    hit = eq_hour && eq_min && eq_sec;
      RPT_HOUR:   hit = eq_min && eq_sec;
      RPT_MINUTE: hit = eq_sec;
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick && hit && en;
  end
endmodule

// File: rtl/bcd_alarm_top.sv
module bcd_alarm_top
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              tick,
  input  logic [7:0]        tod_sec,
  input  logic [7:0]        tod_min,
  input  logic [7:0]        tod_hour,
  input  logic [7:0]        tod_date,
  output logic              irq
);
  logic [FIELDS-1:0][7:0] alarm_regs;
  logic                   alarm_en;
  logic                   alarm_hit;

  alarm_regfile #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_q(alarm_regs), .en_q(alarm_en)
  );

  alarm_match u_match (
    .alarm_q(alarm_regs), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_date(tod_date), .hit(alarm_hit)
  );

  alarm_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hit(alarm_hit),
    .en(alarm_en), .irq(irq)
  );
endmodule

// File: rtl/bcd_alarm_checker.sv
module bcd_alarm_checker
  import bcd_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [7:0]             wr_data,
  input logic                   tick,
  input logic                   irq,
  input logic                   alarm_en,
  input logic [FIELDS-1:0][7:0] alarm_regs
);
  // R10: single-cycle pulse
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10: pulse only follows a sampled tick
  a_r10_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));
  // R11: pulse only while enabled
  a_r11_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(alarm_en));
  // R3: bad low digit in a second write leaves register alone
  a_r3_sec_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(F_SEC) && wr_data[3:0] > 4'd9)
      |=> $stable(alarm_regs[F_SEC]));
  // R5: zero date write leaves register alone
  a_r5_date_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(F_DATE) && wr_data[5:0] == 6'd0)
      |=> $stable(alarm_regs[F_DATE]));
  // R2: writes elsewhere leave the hour register alone
  a_r2_hour_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != ADDR_W'(F_HOUR)) |=> $stable(alarm_regs[F_HOUR]));
endmodule

bind bcd_alarm_top bcd_alarm_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick(tick), .irq(irq), .alarm_en(alarm_en),
  .alarm_regs(alarm_regs)
);

// File: tb/test_bcd_alarm_top.sv
module test_bcd_alarm_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [7:0] tod_sec = '0, tod_min = '0, tod_hour = '0, tod_date = '0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_alarm_top i_bcd_alarm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick),
    .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
    .tod_date(tod_date), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit valid(input int f, input int v);
    int lo, hi, n;
    lo = v & 15;
    case (f)
      0, 1: begin hi = (v >> 4) & 7; n = hi * 10 + lo; return lo <= 9 && n <= 59; end
      2:    begin hi = (v >> 4) & 3; n = hi * 10 + lo; return lo <= 9 && n <= 23; end
      default: begin hi = (v >> 4) & 3; n = hi * 10 + lo; return lo <= 9 && n != 0; end
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 3'(a);
    #1 d = int'(rd_data);
  endtask

  // Apply one tick; return irq one cycle later and the following cycle.
  task automatic pulse(output int first, output int second);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    first = int'(irq);
    @(negedge clk);
    second = int'(irq);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int d, old, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 5; k++) begin rd(k, d); check("R1 reset reg", d, 0); end
    check("R1 reset irq", int'(irq), 0);

    // R3 R4 R5 R6 exhaustive write sweep per field
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 256; v++) begin
        rd(f, old);
        wr(f, v);
        rd(f, d);
        case (f)
          0, 1: check("R3 sec/min write", d, valid(f, v) ? v : old);
          2:    check("R4 hour write", d, valid(f, v) ? v : old);
          default: check("R5 date write", d, valid(f, v) ? v : old);
        endcase
      end
    end
    // R6 full byte kept
    wr(2, 8'hC5); rd(2, d); check("R6 full byte", d, 8'hC5);

    // R2 control and unmapped addresses
    wr(4, 8'hFF); rd(4, d); check("R2 ctrl enable", d, 1);
    wr(5, 8'h12); rd(5, d); check("R2 unmapped read", d, 0);
    for (int k = 0; k < 4; k++) begin
      rd(k, old); wr(7, 8'h11); rd(k, d); check("R2 unmapped write", d, old);
    end

    // R7 R8 R9 mask sweep
    for (int m = 0; m < 16; m++) begin
      int mode, exp;
      wr(0, ((m & 1) ? 8'h80 : 0) | 8'h30);
      wr(1, ((m & 2) ? 8'h80 : 0) | 8'h45);
      wr(2, ((m & 4) ? 8'h80 : 0) | 8'h12);
      wr(3, ((m & 8) ? 8'h80 : 0) | 8'h15);
      // number of fields compared: 4 month, 3 day, 2 hour, 1 minute, 0 second
      mode = (m == 0) ? 4 : (m == 8) ? 3 : (m == 12) ? 2 : (m == 14) ? 1 : 0;
      for (int p = 0; p < 5; p++) begin
        tod_sec = 8'h30; tod_min = 8'h45; tod_hour = 8'h12; tod_date = 8'h15;
        case (p)
          1: tod_sec  = 8'h31;
          2: tod_min  = 8'h44;
          3: tod_hour = 8'h13;
          4: tod_date = 8'h16;
          default: ;
        endcase
        // field p-1 differs; compared fields are sec(0)..(mode-1)
        exp = (p == 0) ? 1 : ((p - 1) < mode ? 0 : 1);
        pulse(a, b);
        if (m == 0) check("R7 monthly", a, exp);
        else if (mode != 0) check("R8 reduced compare", a, exp);
        else check("R9 every second", a, exp);
        check("R10 single cycle", b, 0);
      end
    end

    // R10 no tick, no pulse
    tod_sec = 8'h30;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R10 no tick", int'(irq), 0);
    end

    // R11 enable gating
    wr(4, 0);
    pulse(a, b); check("R11 disabled", a, 0);
    wr(4, 1);
    pulse(a, b); check("R11 enabled", a, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule